// File: doc/BRIEF.md
# Sampling converter conversion control

This block is the digital control and parallel readout for a 16-bit sampling converter. Two active-low command inputs, a select and a read/convert line, are first synchronised to the system clock. They are then combined with a logical OR, so a falling edge on either line starts a conversion while the other line is held low. A command must stay low for a minimum number of clocks before it takes effect. While a conversion runs, the active-low `busy_n` output stays low for a fixed number of clocks. At the end of the conversion, the new result from a stand-in data source is stored in an output register.

The stored word is read as two bytes on an 8-bit bus. A byte-select input picks which half is driven. The bus is enabled only while select is low and read/convert is high. A format input turns the two's complement result into straight binary by inverting the top bit. A power-down input blocks new conversions and leaves the stored result as it is. Commands that arrive while `busy_n` is low are dropped.

Top module: `sample_conv_ctrl`

## Requirements
- R1: With `cs_n` held low, a falling edge on `rc_n` that keeps the line low for at least MIN_PULSE clocks starts a conversion.
- R2: With `rc_n` held low, a falling edge on `cs_n` that keeps the line low for at least MIN_PULSE clocks starts a conversion.
- R3: A command that is low for fewer than MIN_PULSE clocks starts no conversion, and the stored result does not change.
- R4: `busy_n` stays low for exactly CONV_CYCLES clocks. When it returns high, the output register already holds the value `result_in` had on the final clock of the conversion.
- R5: A command issued while `busy_n` is low is ignored. It causes no second conversion, and the stored result is the one from the running conversion.
- R6: `busy_n` falls on the (MIN_PULSE+2)-th rising clock edge after the edge at which the raw command line is first seen low. This count includes the two synchroniser stages.
- R7: With `byte_sel` = 0 the bus carries bits 15..8 of the output word. With `byte_sel` = 1 it carries bits 7..0.
- R8: `dbus_oe` is 1 only when `cs_n` = 0 and `rc_n` = 1. While `dbus_oe` is 0, `dbus` is driven to 0.
- R9: While `pwr_dn` = 1, a valid command starts no conversion, and the previously stored result stays readable.
- R10: With `fmt_sb` = 1, bit 15 of the output word is the inverse of the stored bit 15, which gives straight binary. With `fmt_sb` = 0 the stored two's complement word is output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rc_n | input | 1 | Read (high) / convert (low) |
| byte_sel | input | 1 | 0: upper byte, 1: lower byte |
| fmt_sb | input | 1 | 1: straight binary output, 0: two's complement |
| pwr_dn | input | 1 | 1 blocks new conversions |
| result_in | input | 16 | Result from the stand-in data source |
| busy_n | output | 1 | Low while a conversion runs |
| dbus | output | 8 | Selected byte of the output word |
| dbus_oe | output | 1 | Bus drive enable (0 means high impedance) |

## Verification
Conversions are started in two ways: through `rc_n` with select low, and through `cs_n` with read/convert low. These runs show whether the OR-combined command decode treats both lines alike. Pulse lengths just below, exactly at and above the minimum separate the filter's threshold from a plain edge detector. A second command inside a running conversion, and a command under power-down, show whether a started conversion or a blocked one can disturb the stored word. Words with the top bit set and clear, read through both byte selects and both formats, expose swapped halves and errors in the sign-bit inversion.

// File: rtl/sample_conv_ctrl.sv
module sample_conv_ctrl #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 125,
  parameter int MIN_PULSE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              byte_sel,
  input  logic              fmt_sb,
  input  logic              pwr_dn,
  input  logic [DATA_W-1:0] result_in,
  output logic              busy_n,
  output logic [7:0]        dbus,
  output logic              dbus_oe
);
  localparam int HALF = DATA_W / 2;
  localparam int CW   = $clog2(CONV_CYCLES + 1);
  localparam int PW   = $clog2(MIN_PULSE + 1);

  logic [1:0]        cs_sy, rc_sy;
  logic              cmd_q, armed, conv;
  logic [PW-1:0]     low_cnt, low_len;
  logic [CW-1:0]     conv_cnt;
  logic [DATA_W-1:0] res_q, word;
  logic              cmd, go;

  assign cmd = cs_sy[1] | rc_sy[1];

  always_comb begin
    if (cmd_q && !cmd)
      low_len = PW'(1);
    else if (armed && !cmd)
      low_len = (low_cnt == PW'(MIN_PULSE)) ? low_cnt : low_cnt + PW'(1);
    else
      low_len = '0;
  end

  assign go = (low_len == PW'(MIN_PULSE)) && !conv && !pwr_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy    <= 2'b11;
      rc_sy    <= 2'b11;
      cmd_q    <= 1'b1;
      armed    <= 1'b0;
      low_cnt  <= '0;
      conv     <= 1'b0;
      conv_cnt <= '0;
      res_q    <= '0;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      rc_sy <= {rc_sy[0], rc_n};
      cmd_q <= cmd;
      if (go) begin
        conv     <= 1'b1;
        conv_cnt <= CW'(CONV_CYCLES - 1);
        armed    <= 1'b0;
      end else begin
        armed   <= (low_len != '0) && !conv;
        low_cnt <= low_len;
        if (conv) begin
          if (conv_cnt == '0) begin
            conv  <= 1'b0;
            res_q <= result_in;
          end else begin
            conv_cnt <= conv_cnt - CW'(1);
          end
        end
      end
    end
  end

  assign busy_n  = ~conv;
  assign word    = {res_q[DATA_W-1] ^ fmt_sb, res_q[DATA_W-2:0]};
  assign dbus_oe = !cs_n && rc_n;
  assign dbus    = !dbus_oe ? 8'h00 :
                   byte_sel ? word[HALF-1:0] : word[DATA_W-1:HALF];

  p_latch_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> res_q == $past(result_in));
  p_hold_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> ($stable(res_q) || busy_n));
  p_pd_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && busy_n) |=> busy_n);
  p_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(low_len) == PW'(MIN_PULSE) && !$past(cmd)));
  p_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dbus_oe |-> dbus == 8'h00);
endmodule

// File: tb/sample_conv_ctrl_tb_top.sv
module sample_conv_ctrl_tb_top;
  localparam int CONV = 125;
  localparam int MINP = 3;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rc_n = 1, byte_sel = 0, fmt_sb = 0, pwr_dn = 0;
  logic [15:0] result_in = '0;
  logic busy_n, dbus_oe;
  logic [7:0] dbus;
  int checks = 0, fails = 0, width = 0;
  logic prev_b = 1;
  logic [15:0] exp_q[$];
  logic [15:0] e;
  logic [7:0] eb;
  bit done = 0;

  always #10 clk = ~clk;

  sample_conv_ctrl #(.DATA_W(16), .CONV_CYCLES(CONV), .MIN_PULSE(MINP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel),
    .fmt_sb(fmt_sb), .pwr_dn(pwr_dn), .result_in(result_in),
    .busy_n(busy_n), .dbus(dbus), .dbus_oe(dbus_oe));

  function automatic logic [15:0] fmtw(logic [15:0] v, logic f);
    return {v[15] ^ f, v[14:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!busy_n) width++;
    else if (!prev_b) begin
      chk(width == CONV, "R4 busy low length", width, CONV);
      if (exp_q.size() == 0) chk(0, "R5 unexpected conversion", 1, 0);
      else begin
        e  = fmtw(exp_q.pop_front(), fmt_sb);
        eb = (!cs_n && rc_n) ? (byte_sel ? e[7:0] : e[15:8]) : 8'h00;
        chk(dbus == eb, "R4 byte at busy rise", dbus, eb);
      end
      width = 0;
    end
    prev_b = busy_n;
  end

  task automatic pulse(bit via_cs, int n, bit expect_go, bit timing, string tag);
    @(negedge clk);
    if (via_cs) begin cs_n = 1; rc_n = 0; end else begin cs_n = 0; rc_n = 1; end
    repeat (4) @(negedge clk);
    if (expect_go) exp_q.push_back(result_in);
    if (via_cs) cs_n = 0; else rc_n = 0;
    for (int j = 1; j <= ((n > MINP + 2) ? n : MINP + 2); j++) begin
      @(negedge clk);
      if (j == n) begin if (via_cs) cs_n = 1; else rc_n = 1; end
      if (timing && j == MINP + 1) chk(busy_n == 1, {tag, " R6 busy before start"}, busy_n, 1);
      if (timing && j == MINP + 2) chk(busy_n == !expect_go, tag, busy_n, !expect_go);
    end
    rc_n = 1;
  endtask

  task automatic wait_idle();
    while (!busy_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_bytes(logic [15:0] raw, string tag);
    logic [15:0] w;
    w = fmtw(raw, fmt_sb);
    @(negedge clk); cs_n = 0; rc_n = 1; byte_sel = 0;
    @(negedge clk);
    chk(dbus_oe == 1, "R8 bus enabled for read", dbus_oe, 1);
    chk(dbus == w[15:8], {tag, " R7 upper byte"}, dbus, w[15:8]);
    byte_sel = 1;
    @(negedge clk);
    chk(dbus == w[7:0], {tag, " R7 lower byte"}, dbus, w[7:0]);
    byte_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_n == 1, "reset busy_n", busy_n, 1);
    chk(dbus_oe == 0 && dbus == 0, "R8 reset bus quiet", dbus, 0);
    rst_n = 1;
    read_bytes(16'h0000, "reset");

    result_in = 16'hA5C3;
    pulse(0, 5, 1, 1, "R1 rc_n start");
    wait_idle();
    read_bytes(16'hA5C3, "R1");

    cs_n = 0; rc_n = 0;
    @(negedge clk);
    chk(dbus_oe == 0 && dbus == 0, "R8 rc_n low hides bus", {dbus_oe, dbus}, 0);
    cs_n = 1; rc_n = 1;
    @(negedge clk);
    chk(dbus_oe == 0 && dbus == 0, "R8 cs_n high hides bus", {dbus_oe, dbus}, 0);

    result_in = 16'h1234;
    pulse(1, MINP, 1, 1, "R2 cs_n start at minimum");
    wait_idle();
    read_bytes(16'h1234, "R2");

    result_in = 16'hFFFF;
    pulse(0, MINP - 1, 0, 1, "R3 short pulse");
    repeat (CONV + 10) @(negedge clk);
    chk(busy_n == 1, "R3 still idle", busy_n, 1);
    read_bytes(16'h1234, "R3");

    result_in = 16'h8001;
    pulse(0, 4, 1, 1, "R5 first command");
    pulse(0, 6, 0, 0, "R5 ignored command");
    chk(busy_n == 0, "R5 conversion still running", busy_n, 0);
    wait_idle();
    repeat (CONV + 10) @(negedge clk);
    chk(busy_n == 1, "R5 no second conversion", busy_n, 1);
    read_bytes(16'h8001, "R5");

    fmt_sb = 1;
    read_bytes(16'h8001, "R10 sign set");
    result_in = 16'h7F10;
    pulse(0, 8, 1, 1, "R10 convert");
    wait_idle();
    read_bytes(16'h7F10, "R10 sign clear");
    fmt_sb = 0;
    read_bytes(16'h7F10, "R10 twos complement");

    pwr_dn = 1;
    result_in = 16'h5555;
    pulse(0, 6, 0, 1, "R9 power-down");
    repeat (CONV + 10) @(negedge clk);
    chk(busy_n == 1, "R9 no conversion", busy_n, 1);
    read_bytes(16'h7F10, "R9 kept");
    pwr_dn = 0;
    pulse(1, 6, 1, 1, "R9 after power-up");
    wait_idle();
    read_bytes(16'h5555, "R9 new");

    chk(exp_q.size() == 0, "R4 all conversions seen", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule